// File: doc/BRIEF.md
# Level-Sensitive Interrupt Aggregator

This block collects thirty-two level-sensitive interrupt inputs and reduces them to one interrupt line for a parent controller. Each input passes through a two-flop synchronizer and then an optional inversion, so a source can be active-high or active-low. The corrected level sets a sticky pending bit. Software clears pending bits by writing ones to the status register. A per-source enable mask and a global gate bit decide whether pending bits drive the combined output.

Software reaches the block through a single-cycle register bus with byte offsets. Source number n appears at register bit 31−n, so source 0 is the most significant bit of every per-source register. A source that is still asserted becomes pending again straight after a clear. The interrupt service routine therefore sees a non-zero status until the device releases its line.

Top module: `lvl_irq_ctrl`

## Requirements
- R1: Source n (pin `srcIn[n]`) maps to bit 31−n of the status, enable, polarity and raw registers, so source 0 is bit 31.
- R2: The registers sit at byte offsets 0x04 (global gate), 0x50 (status), 0x54 (enable) and 0x58 (polarity), all readable, and 0x5C (raw inputs). The global gate, enable and polarity registers read back the value last written. A read of any other offset returns 0.
- R3: A polarity bit of 0 makes its source asserted when the synchronized pin is 1. A polarity bit of 1 makes it asserted when the pin is 0.
- R4: A write to the status register clears every pending bit whose write-data bit is 1 and leaves the bits written with 0 unchanged. Writing 0xFFFFFFFF clears all bits whose source is not asserted.
- R5: A pending bit whose source is still asserted sets again on the same cycle, winning over a clear, so status stays non-zero until the source is released.
- R6: `irqOut` is 1 exactly when bit 0 of the global gate register is 1 and (status AND enable) is non-zero. The other gate bits have no effect.
- R7: A pending bit sets whenever its corrected input is asserted, whatever its enable bit.
- R8: A read of offset 0x5C returns the synchronized pins before polarity correction. Writes to that offset have no effect.
- R9: An input change reaches the pending bits, and so `irqOut`, on the third rising clock edge after it is applied: two synchronizer edges, then the pending register.
- R10: Reset clears every register. After reset all reads return 0 and `irqOut` is 0.
- R11: Read data is registered: `busRdata` holds the addressed value from the first rising edge after a cycle with `busRd` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busAddr | input | 8 | Byte offset of the access |
| busWr | input | 1 | Write strobe, one cycle |
| busRd | input | 1 | Read request, one cycle |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Registered read data |
| srcIn | input | 32 | Interrupt source pins, bit n is source n |
| irqOut | output | 1 | Combined interrupt to the parent |

## Verification
The main path is driven from a vector table. Its patterns are: a lone source 0 at the top bit; a lone source 31 with its enable cleared; all sources inverted with only one pin low; half the sources inverted with the global gate off; checkerboard inputs against a complementary enable; a gate word with only bit 1 set; and inputs that equal their polarity. Together these separate a reversed bit order, a missing or global inversion, an enable that blocks latching, and a gate that looks at more than bit 0. Directed tests then cover the three-edge latency, re-pending under a held level, partial write-one-to-clear, raw-register reads and writes, and undefined offsets.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 8;

  localparam logic [ADDR_W-1:0] OFS_GLOBAL = 8'h04;
  localparam logic [ADDR_W-1:0] OFS_STATUS = 8'h50;
  localparam logic [ADDR_W-1:0] OFS_ENABLE = 8'h54;
  localparam logic [ADDR_W-1:0] OFS_POLAR  = 8'h58;
  localparam logic [ADDR_W-1:0] OFS_RAW    = 8'h5C;

  typedef enum logic [2:0] {
    RD_NONE, RD_GLOBAL, RD_STATUS, RD_ENABLE, RD_POLAR, RD_RAW
  } rdSel_e;

  typedef struct packed {
    logic   wrGlobal;
    logic   wrStatus;
    logic   wrEnable;
    logic   wrPolar;
    logic   rdStrobe;
    rdSel_e rdSel;
  } busStrobe_t;
endpackage

// File: rtl/irqc_ctrl.sv
module irqc_ctrl
  import irqc_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWr,
  input  logic              busRd,
  output busStrobe_t        strobe
);
  always_comb begin
    strobe = '0;
    strobe.rdSel    = RD_NONE;
    strobe.rdStrobe = busRd;
    if (busWr) begin
      unique case (busAddr)
        OFS_GLOBAL: strobe.wrGlobal = 1'b1;
        OFS_STATUS: strobe.wrStatus = 1'b1;
        OFS_ENABLE: strobe.wrEnable = 1'b1;
        OFS_POLAR:  strobe.wrPolar  = 1'b1;
        default:    ;
      endcase
    end
    if (busRd) begin
      unique case (busAddr)
        OFS_GLOBAL: strobe.rdSel = RD_GLOBAL;
        OFS_STATUS: strobe.rdSel = RD_STATUS;
        OFS_ENABLE: strobe.rdSel = RD_ENABLE;
        OFS_POLAR:  strobe.rdSel = RD_POLAR;
        OFS_RAW:    strobe.rdSel = RD_RAW;
        default:    strobe.rdSel = RD_NONE;
      endcase
    end
  end

  // R2 / R8: one write target at most, and the raw offset never writes
  a_r2_single_target: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.wrGlobal, strobe.wrStatus, strobe.wrEnable, strobe.wrPolar}));
  a_r8_raw_no_write: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && busAddr == OFS_RAW) |->
      !(strobe.wrGlobal || strobe.wrStatus || strobe.wrEnable || strobe.wrPolar));
endmodule

// File: rtl/irqc_datapath.sv
module irqc_datapath
  import irqc_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  busStrobe_t        strobe,
  input  logic [DATA_W-1:0] busWdata,
  input  logic [DATA_W-1:0] srcIn,
  output logic [DATA_W-1:0] busRdata,
  output logic              irqOut
);
  localparam int TOP = DATA_W - 1;

  logic [DATA_W-1:0] pinsByBit;
  logic [SYNC_STAGES-1:0][DATA_W-1:0] syncPipe;
  logic [DATA_W-1:0] rawSync, asserted, clearMask, pendNext;
  logic [DATA_W-1:0] globReg, pendReg, enReg, polReg;
  logic [DATA_W-1:0] rdMux;

  // Source n lands on register bit TOP-n
  for (genvar n = 0; n < DATA_W; n++) begin : g_rev
    assign pinsByBit[TOP-n] = srcIn[n];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncPipe <= '0;
    end else begin
      syncPipe[0] <= pinsByBit;
      for (int s = 1; s < SYNC_STAGES; s++) syncPipe[s] <= syncPipe[s-1];
    end
  end

  assign rawSync   = syncPipe[SYNC_STAGES-1];
  assign asserted  = rawSync ^ polReg;
  assign clearMask = strobe.wrStatus ? busWdata : '0;
  assign pendNext  = (pendReg & ~clearMask) | asserted;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      globReg <= '0;
      pendReg <= '0;
      enReg   <= '0;
      polReg  <= '0;
    end else begin
      pendReg <= pendNext;
      if (strobe.wrGlobal) globReg <= busWdata;
      if (strobe.wrEnable) enReg   <= busWdata;
      if (strobe.wrPolar)  polReg  <= busWdata;
    end
  end

  assign irqOut = globReg[0] & (|(pendReg & enReg));

  always_comb begin
    unique case (strobe.rdSel)
      RD_GLOBAL: rdMux = globReg;
      RD_STATUS: rdMux = pendReg;
      RD_ENABLE: rdMux = enReg;
      RD_POLAR:  rdMux = polReg;
      RD_RAW:    rdMux = rawSync;
      default:   rdMux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                busRdata <= '0;
    else if (strobe.rdStrobe) busRdata <= rdMux;
  end

  a_r4_ones_clear: assert property (@(posedge clk) disable iff (!rstN)
    strobe.wrStatus |=> ((pendReg & $past(busWdata) & ~$past(asserted)) == '0));
  a_r4_no_spurious_clear: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.wrStatus |=> (($past(pendReg) & ~pendReg) == '0));
  a_r5_level_repend: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((pendReg & $past(asserted)) == $past(asserted)));
  a_r7_set_only_when_asserted: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((pendReg & ~$past(pendReg) & ~$past(asserted)) == '0));
  a_r8_raw_readback: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.rdStrobe && strobe.rdSel == RD_RAW) |=> (busRdata == $past(rawSync)));
endmodule

// File: rtl/lvl_irq_ctrl.sv
module lvl_irq_ctrl
  import irqc_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [7:0]  busAddr,
  input  logic        busWr,
  input  logic        busRd,
  input  logic [31:0] busWdata,
  output logic [31:0] busRdata,
  input  logic [31:0] srcIn,
  output logic        irqOut
);
  busStrobe_t strobe;

  irqc_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .busAddr(busAddr),
    .busWr(busWr), .busRd(busRd), .strobe(strobe)
  );

  irqc_datapath #(.SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .busWdata(busWdata),
    .srcIn(srcIn), .busRdata(busRdata), .irqOut(irqOut)
  );

  // R6: with the gate bit low the line stays quiet
  a_r6_gate_low_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !u_dp.globReg[0] |-> !irqOut);
endmodule

// File: tb/lvl_irq_ctrl_bench.sv
module lvl_irq_ctrl_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  busAddr = '0;
  logic        busWr = 1'b0, busRd = 1'b0;
  logic [31:0] busWdata = '0, busRdata, srcIn = '0;
  logic        irqOut;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  lvl_irq_ctrl u_lvl_irq_ctrl (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWr(busWr), .busRd(busRd),
    .busWdata(busWdata), .busRdata(busRdata), .srcIn(srcIn), .irqOut(irqOut)
  );

  typedef struct packed {
    logic [31:0] pol, en, glob, raw, expStat;
    logic        expIrq;
  } vec_t;

  localparam int NVEC = 7;
  localparam vec_t VECS [NVEC] = '{
    '{32'h0000_0000, 32'hFFFF_FFFF, 32'h1, 32'h8000_0000, 32'h8000_0000, 1'b1},
    '{32'h0000_0000, 32'h0000_0000, 32'h1, 32'h0000_0001, 32'h0000_0001, 1'b0},
    '{32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h1, 32'hFFFF_FFFE, 32'h0000_0001, 1'b1},
    '{32'h0000_FFFF, 32'h0000_FFFF, 32'h0, 32'h0000_0000, 32'h0000_FFFF, 1'b0},
    '{32'h0000_0000, 32'h0F0F_0F0F, 32'h1, 32'hF0F0_F0F0, 32'hF0F0_F0F0, 1'b0},
    '{32'h0000_0000, 32'h0F0F_0F0F, 32'h2, 32'h0100_0000, 32'h0100_0000, 1'b0},
    '{32'hAAAA_AAAA, 32'hFFFF_FFFF, 32'h1, 32'hAAAA_AAAA, 32'h0000_0000, 1'b0}
  };

  function automatic logic [31:0] toPins(input logic [31:0] w);
    logic [31:0] p;
    for (int i = 0; i < 32; i++) p[i] = w[31-i];
    return p;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    busAddr = a; busWdata = d; busWr = 1'b1;
    @(negedge clk);
    busWr = 1'b0; busWdata = '0;
  endtask

  task automatic busRead(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    busAddr = a; busRd = 1'b1;
    @(negedge clk);
    busRd = 1'b0;
    d = busRdata;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic finishRun();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    logic [31:0] rd;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R10: reset state
    busRead(8'h04, rd); check("R10 global", rd, 0);
    busRead(8'h50, rd); check("R10 status", rd, 0);
    busRead(8'h54, rd); check("R10 enable", rd, 0);
    busRead(8'h58, rd); check("R10 polarity", rd, 0);
    check("R10 irqOut", {31'b0, irqOut}, 0);

    // Vector table: R1 R3 R6 R7
    for (int v = 0; v < NVEC; v++) begin
      busWrite(8'h58, VECS[v].pol);
      @(negedge clk); srcIn = toPins(VECS[v].pol);
      settle();
      busWrite(8'h50, 32'hFFFF_FFFF);
      busWrite(8'h54, VECS[v].en);
      busWrite(8'h04, VECS[v].glob);
      @(negedge clk); srcIn = toPins(VECS[v].raw);
      settle();
      busRead(8'h50, rd);
      check($sformatf("R1/R3/R7 vec%0d status", v), rd, VECS[v].expStat);
      check($sformatf("R6 vec%0d irqOut", v), {31'b0, irqOut}, {31'b0, VECS[v].expIrq});
      @(negedge clk); srcIn = toPins(VECS[v].pol);
      settle();
      busWrite(8'h50, 32'hFFFF_FFFF);
    end

    // R2 readback and undefined offset
    busWrite(8'h58, 32'h0000_0000);
    busWrite(8'h54, 32'h1234_5678); busRead(8'h54, rd); check("R2 enable readback", rd, 32'h1234_5678);
    busWrite(8'h04, 32'h0000_0003); busRead(8'h04, rd); check("R2 global readback", rd, 32'h3);
    busWrite(8'h08, 32'hFFFF_FFFF); busRead(8'h08, rd); check("R2 undefined offset", rd, 0);

    // R8: raw view is pre-polarity and read-only
    @(negedge clk); srcIn = 32'h0000_0001;
    busWrite(8'h58, 32'hFFFF_FFFF);
    settle();
    busWrite(8'h5C, 32'h0000_FFFF);
    busRead(8'h5C, rd); check("R8 raw pre-polarity", rd, 32'h8000_0000);
    busWrite(8'h58, 32'h0000_0000);
    @(negedge clk); srcIn = '0;
    settle();
    busWrite(8'h50, 32'hFFFF_FFFF);

    // R9: three-edge latency, visible on irqOut
    busWrite(8'h54, 32'hFFFF_FFFF);
    busWrite(8'h04, 32'h1);
    @(negedge clk); srcIn = 32'h8000_0000;
    @(negedge clk); @(negedge clk);
    check("R9 not yet after two edges", {31'b0, irqOut}, 0);
    @(negedge clk);
    check("R9 set on third edge", {31'b0, irqOut}, 1);

    // R5: held level re-pends after clear
    busWrite(8'h50, 32'hFFFF_FFFF);
    busRead(8'h50, rd); check("R5 repend while held", rd, 32'h0000_0001);
    @(negedge clk); srcIn = '0;
    settle();
    busWrite(8'h50, 32'h0000_0001);
    busRead(8'h50, rd); check("R5 clears after release", rd, 0);

    // R4: partial write-one-to-clear on sticky bits
    @(negedge clk); srcIn = 32'h0000_0003;
    settle();
    @(negedge clk); srcIn = '0;
    settle();
    busWrite(8'h50, 32'h0000_0000);
    busRead(8'h50, rd); check("R4 zero write keeps", rd, 32'hC000_0000);
    busWrite(8'h50, 32'h4000_0000);
    busRead(8'h50, rd); check("R4 one bit cleared", rd, 32'h8000_0000);
    check("R6 sticky drives irqOut", {31'b0, irqOut}, 1);

    // R11: data appears one edge after the request
    @(negedge clk); busAddr = 8'h50; busRd = 1'b1;
    @(negedge clk); busRd = 1'b0; busAddr = 8'h08;
    check("R11 registered read", busRdata, 32'h8000_0000);
    @(negedge clk);
    check("R11 holds without request", busRdata, 32'h8000_0000);

    finishRun();
  end
endmodule